// File: doc/BRIEF.md
# Plug-and-play logical device decoder

This block holds the configuration state of one plug-and-play logical device on an ISA-style I/O bus. Software reaches the state through a small configuration port: an 8-bit register index, write data with a write strobe, and a read strobe with combinational read data. Through this port software programs the device's I/O base address, picks its interrupt line and finally switches the device on.

On the I/O side the block watches a 10-bit address with read and write strobes. Once the device is switched on, any bus cycle that falls inside the device's eight-byte window raises a chip select for the attached serial controller. The low three address bits are passed along as the register offset. The controller's interrupt request is steered onto the one IRQ output that software chose, provided that line is in the legal set.

While the device is switched off, it can answer a conflict probe. With the probe enabled, reads inside the programmed window return a fixed byte pattern. This lets configuration software detect whether another card already uses that range. The block stays silent on the bus in every other case while it is switched off.

Top module: `pnp_ldev_decoder`

## Requirements
- R1: Configuration index 0x30 holds the device enable in bit 0. Bits 7:1 read as zero, and writes to them are ignored.
- R2: While the device is disabled, `cs` stays low for every I/O cycle. `io_rdata_oe` is also low unless the probe of R3 applies.
- R3: Configuration index 0x31 holds the probe enable in bit 1 and the pattern select in bit 0; the other bits read as zero. The probe applies when the device is disabled, the probe is enabled, `io_rd` is high and io_addr[9:3] equals the base. In that case `io_rdata_oe` is high and `io_rdata` is 0x55 when bit 0 is 1, or 0xAA when bit 0 is 0. Otherwise `io_rdata_oe` and `io_rdata` are both zero.
- R4: While the device is enabled, the probe setting has no effect: `io_rdata_oe` stays low.
- R5: Configuration index 0x60 holds base address bits 9:8 in its bits 1:0. Bits 7:2 read as zero and ignore writes.
- R6: Configuration index 0x61 holds base address bits 7:3 in its bits 7:3. Bits 2:0 read as zero and ignore writes.
- R7: `cs` is high exactly when the device is enabled, `io_rd` or `io_wr` is high, and io_addr[9:3] equals the base. `reg_ofs` equals io_addr[2:0] while `cs` is high, and is zero otherwise.
- R8: Configuration index 0x70 holds the interrupt level in bits 3:0. Bits 7:4 read as zero and ignore writes.
- R9: Bit n of `irq_out` follows `ctl_irq` only when the device is enabled and the level equals n. The level must also be one of 2 to 7 or 9 to 12. In every other case `irq_out` is all zero.
- R10: Index 0x71 reads 0x03, and indices 0x74 and 0x75 read 0x04. Writes to these indices are ignored.
- R11: A read of any other index returns 0x00. `cfg_rdata` is zero while `cfg_rd` is low.
- R12: A synchronous reset returns every register to zero. A configuration write becomes visible on the clock edge at which `cfg_wr` is sampled high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_rdata | output | 8 | Configuration read data |
| io_addr | input | 10 | I/O bus address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 8 | Probe response byte |
| io_rdata_oe | output | 1 | Probe response drive enable |
| cs | output | 1 | Chip select to the serial controller |
| reg_ofs | output | 3 | Register offset to the serial controller |
| ctl_irq | input | 1 | Interrupt request from the serial controller |
| irq_out | output | 16 | Steered interrupt lines, bit n is IRQn |

## Verification
Every output on the I/O side is a combinational function of the stored state. A corrupted enable bit, base field or level field therefore shows up in the same cycle as the next bus access or interrupt that touches it. It appears as a missing or extra chip select, a probe byte driven while enabled, or an interrupt on the wrong line. Register faults also show up on the first configuration read after the faulty write edge, because read data comes straight from the stored bits.

// File: rtl/pnp_ldev_pkg.sv
package pnp_ldev_pkg;

   // configuration index map
   localparam logic [7:0] IDX_ENABLE   = 8'h30;
   localparam logic [7:0] IDX_PROBE    = 8'h31;
   localparam logic [7:0] IDX_BASE_HI  = 8'h60;
   localparam logic [7:0] IDX_BASE_LO  = 8'h61;
   localparam logic [7:0] IDX_IRQ_LVL  = 8'h70;
   localparam logic [7:0] IDX_IRQ_KIND = 8'h71;
   localparam logic [7:0] IDX_DMA_A    = 8'h74;
   localparam logic [7:0] IDX_DMA_B    = 8'h75;

   // fixed read-only values
   localparam logic [7:0] IRQ_KIND_VAL = 8'h03;   // active high, level
   localparam logic [7:0] DMA_NONE_VAL = 8'h04;   // no channel

   // probe patterns
   localparam logic [7:0] PROBE_PAT_SET = 8'h55;
   localparam logic [7:0] PROBE_PAT_CLR = 8'hAA;

   typedef struct packed {
      logic enable;     // device switched on
      logic probe_en;   // conflict probe armed
      logic probe_sel;  // pattern choice
   } ldev_flags_t;

endpackage

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
   import pnp_ldev_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int OFS_W  = 3,
   parameter int SEL_W  = 4,
   localparam int BASE_W = ADDR_W - OFS_W,
   localparam int HI_W   = ADDR_W - 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        cfg_idx,
   input  logic [7:0]        cfg_wdata,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   output logic [7:0]        cfg_rdata,
   output ldev_flags_t       flags,
   output logic [BASE_W-1:0] base,
   output logic [SEL_W-1:0]  irq_sel
);

   ldev_flags_t             flags_q;
   logic [ADDR_W-1:OFS_W]   base_q;
   logic [SEL_W-1:0]        sel_q;

   // register updates
   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= '0;
         base_q  <= '0;
         sel_q   <= '0;
      end else if (cfg_wr) begin
         case (cfg_idx)
            IDX_ENABLE:  flags_q.enable <= cfg_wdata[0];
            IDX_PROBE: begin
               flags_q.probe_en  <= cfg_wdata[1];
               flags_q.probe_sel <= cfg_wdata[0];
            end
            IDX_BASE_HI: base_q[ADDR_W-1:8]  <= cfg_wdata[HI_W-1:0];
            IDX_BASE_LO: base_q[7:OFS_W]     <= cfg_wdata[7:OFS_W];
            IDX_IRQ_LVL: sel_q               <= cfg_wdata[SEL_W-1:0];
            default: ;
         endcase
      end
   end

   // readback views
   logic [7:0] rd_enable;
   logic [7:0] rd_probe;
   logic [7:0] rd_base_hi;
   logic [7:0] rd_base_lo;
   logic [7:0] rd_level;

   assign rd_enable  = {7'b0, flags_q.enable};
   assign rd_probe   = {6'b0, flags_q.probe_en, flags_q.probe_sel};
   assign rd_base_hi = {{(8-HI_W){1'b0}}, base_q[ADDR_W-1:8]};
   assign rd_base_lo = {base_q[7:OFS_W], {OFS_W{1'b0}}};
   assign rd_level   = {{(8-SEL_W){1'b0}}, sel_q};

   always_comb begin
      cfg_rdata = '0;
      if (cfg_rd) begin
         case (cfg_idx)
            IDX_ENABLE:   cfg_rdata = rd_enable;
            IDX_PROBE:    cfg_rdata = rd_probe;
            IDX_BASE_HI:  cfg_rdata = rd_base_hi;
            IDX_BASE_LO:  cfg_rdata = rd_base_lo;
            IDX_IRQ_LVL:  cfg_rdata = rd_level;
            IDX_IRQ_KIND: cfg_rdata = IRQ_KIND_VAL;
            IDX_DMA_A:    cfg_rdata = DMA_NONE_VAL;
            IDX_DMA_B:    cfg_rdata = DMA_NONE_VAL;
            default:      cfg_rdata = '0;
         endcase
      end
   end

   assign flags   = flags_q;
   assign base    = base_q;
   assign irq_sel = sel_q;

endmodule

// File: rtl/pnp_io_decode.sv
module pnp_io_decode
   import pnp_ldev_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int OFS_W       = 3,
   parameter bit PROBE_SUPPORT = 1'b1,
   localparam int BASE_W = ADDR_W - OFS_W
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  ldev_flags_t       flags,
   input  logic [BASE_W-1:0] base,
   output logic              cs,
   output logic [OFS_W-1:0]  reg_ofs,
   output logic [7:0]        io_rdata,
   output logic              io_rdata_oe
);

   logic window_hit;
   logic bus_cycle;

   assign window_hit = (io_addr[ADDR_W-1:OFS_W] == base);
   assign bus_cycle  = io_rd | io_wr;

   assign cs      = flags.enable & bus_cycle & window_hit;
   assign reg_ofs = cs ? io_addr[OFS_W-1:0] : '0;

   generate
      if (PROBE_SUPPORT) begin : g_probe
         logic probe_hit;
         assign probe_hit   = ~flags.enable & flags.probe_en & io_rd & window_hit;
         assign io_rdata_oe = probe_hit;
         assign io_rdata    = !probe_hit      ? 8'h00 :
                              flags.probe_sel ? PROBE_PAT_SET : PROBE_PAT_CLR;
      end else begin : g_no_probe
         logic unused_probe;
         assign unused_probe = flags.probe_en ^ flags.probe_sel;
         assign io_rdata_oe  = 1'b0;
         assign io_rdata     = 8'h00;
      end
   endgenerate

endmodule

// File: rtl/pnp_irq_route.sv
module pnp_irq_route #(
   parameter int SEL_W = 4,
   localparam int LINES = 1 << SEL_W,
   parameter logic [LINES-1:0] LEGAL_MASK = 16'h1EFC
) (
   input  logic             enable,
   input  logic [SEL_W-1:0] irq_sel,
   input  logic             ctl_irq,
   output logic [LINES-1:0] irq_out
);

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         if (LEGAL_MASK[i]) begin : g_legal
            assign irq_out[i] = enable & ctl_irq & (irq_sel == SEL_W'(i));
         end else begin : g_tied
            assign irq_out[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/pnp_ldev_decoder.sv
module pnp_ldev_decoder
   import pnp_ldev_pkg::*;
#(
   parameter int ADDR_W        = 10,
   parameter int OFS_W         = 3,
   parameter int SEL_W         = 4,
   parameter bit PROBE_SUPPORT = 1'b1,
   localparam int LINES  = 1 << SEL_W,
   localparam int BASE_W = ADDR_W - OFS_W,
   parameter logic [LINES-1:0] LEGAL_MASK = 16'h1EFC
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        cfg_idx,
   input  logic [7:0]        cfg_wdata,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   output logic [7:0]        cfg_rdata,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   output logic [7:0]        io_rdata,
   output logic              io_rdata_oe,
   output logic              cs,
   output logic [OFS_W-1:0]  reg_ofs,
   input  logic              ctl_irq,
   output logic [LINES-1:0]  irq_out
);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 9 || ADDR_W > 15) begin : g_bad_addr_w
         $error("pnp_ldev_decoder: ADDR_W must be 9..15");
      end
      if (OFS_W < 1 || OFS_W > 7) begin : g_bad_ofs_w
         $error("pnp_ldev_decoder: OFS_W must be 1..7");
      end
      if (SEL_W < 1 || SEL_W > 7) begin : g_bad_sel_w
         $error("pnp_ldev_decoder: SEL_W must be 1..7");
      end
   endgenerate

   ldev_flags_t       flags;
   logic [BASE_W-1:0] base_q;
   logic [SEL_W-1:0]  irq_sel;
   logic              dev_active;

   pnp_cfg_regs #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W),
      .SEL_W  (SEL_W)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .cfg_wr    (cfg_wr),
      .cfg_rd    (cfg_rd),
      .cfg_rdata (cfg_rdata),
      .flags     (flags),
      .base      (base_q),
      .irq_sel   (irq_sel)
   );

   assign dev_active = flags.enable;

   pnp_io_decode #(
      .ADDR_W        (ADDR_W),
      .OFS_W         (OFS_W),
      .PROBE_SUPPORT (PROBE_SUPPORT)
   ) u_decode (
      .io_addr     (io_addr),
      .io_rd       (io_rd),
      .io_wr       (io_wr),
      .flags       (flags),
      .base        (base_q),
      .cs          (cs),
      .reg_ofs     (reg_ofs),
      .io_rdata    (io_rdata),
      .io_rdata_oe (io_rdata_oe)
   );

   pnp_irq_route #(
      .SEL_W      (SEL_W),
      .LEGAL_MASK (LEGAL_MASK)
   ) u_irq (
      .enable  (dev_active),
      .irq_sel (irq_sel),
      .ctl_irq (ctl_irq),
      .irq_out (irq_out)
   );

endmodule

// File: rtl/pnp_ldev_decoder_chk.sv
module pnp_ldev_decoder_chk
   import pnp_ldev_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int OFS_W  = 3,
   parameter int SEL_W  = 4,
   localparam int LINES  = 1 << SEL_W,
   localparam int BASE_W = ADDR_W - OFS_W,
   parameter logic [LINES-1:0] LEGAL_MASK = 16'h1EFC
) (
   input logic              clk,
   input logic              rst,
   input logic [7:0]        cfg_idx,
   input logic              cfg_wr,
   input logic              en_wbit,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic              cs,
   input logic              io_rdata_oe,
   input logic [LINES-1:0]  irq_out,
   input logic              dev_active,
   input logic [BASE_W-1:0] base_q,
   input logic [SEL_W-1:0]  irq_sel
);

   // R1: enable bit takes the written value
   a_r1_enable_write: assert property (@(posedge clk) disable iff (rst)
      (cfg_wr && cfg_idx == IDX_ENABLE) |=> (dev_active == $past(en_wbit)));

   // R12: no write, no change of the enable bit
   a_r12_enable_hold: assert property (@(posedge clk) disable iff (rst)
      !cfg_wr |=> $stable(dev_active));

   // R2: chip select needs an enabled device
   a_r2_cs_needs_enable: assert property (@(posedge clk) disable iff (rst)
      cs |-> dev_active);

   // R4: probe response only while disabled
   a_r4_probe_only_off: assert property (@(posedge clk) disable iff (rst)
      io_rdata_oe |-> (!dev_active && io_rd));

   // R7: chip select only inside the programmed window during a bus cycle
   a_r7_cs_in_window: assert property (@(posedge clk) disable iff (rst)
      cs |-> ((io_addr[ADDR_W-1:OFS_W] == base_q) && (io_rd || io_wr)));

   // R9: at most one interrupt line, always a legal one, matching the level
   a_r9_irq_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(irq_out));

   a_r9_irq_legal: assert property (@(posedge clk) disable iff (rst)
      (irq_out & ~LEGAL_MASK) == '0);

   a_r9_irq_on_level: assert property (@(posedge clk) disable iff (rst)
      (irq_out != '0) |-> (irq_out[irq_sel] && dev_active));

endmodule

bind pnp_ldev_decoder pnp_ldev_decoder_chk #(
   .ADDR_W     (ADDR_W),
   .OFS_W      (OFS_W),
   .SEL_W      (SEL_W),
   .LEGAL_MASK (LEGAL_MASK)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cfg_idx     (cfg_idx),
   .cfg_wr      (cfg_wr),
   .en_wbit     (cfg_wdata[0]),
   .io_addr     (io_addr),
   .io_rd       (io_rd),
   .io_wr       (io_wr),
   .cs          (cs),
   .io_rdata_oe (io_rdata_oe),
   .irq_out     (irq_out),
   .dev_active  (dev_active),
   .base_q      (base_q),
   .irq_sel     (irq_sel)
);

// File: tb/pnp_ldev_decoder_test.sv
module pnp_ldev_decoder_test;

   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  cfg_idx;
   logic [7:0]  cfg_wdata;
   logic        cfg_wr;
   logic        cfg_rd;
   logic [7:0]  cfg_rdata;
   logic [9:0]  io_addr;
   logic        io_rd;
   logic        io_wr;
   logic [7:0]  io_rdata;
   logic        io_rdata_oe;
   logic        cs;
   logic [2:0]  reg_ofs;
   logic        ctl_irq;
   logic [15:0] irq_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   pnp_ldev_decoder uut (
      .clk(clk), .rst(rst),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr),
      .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
      .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
      .cs(cs), .reg_ofs(reg_ofs),
      .ctl_irq(ctl_irq), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] idx, input logic [7:0] data);
      @(negedge clk);
      cfg_idx = idx; cfg_wdata = data; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] idx, output logic [7:0] data);
      @(negedge clk);
      cfg_idx = idx; cfg_rd = 1'b1;
      #1 data = cfg_rdata;
      cfg_rd = 1'b0;
   endtask

   task automatic io_cycle(input logic [9:0] a, input logic rd, input logic wr);
      @(negedge clk);
      io_addr = a; io_rd = rd; io_wr = wr;
      #1;
   endtask

   task automatic io_idle();
      io_rd = 1'b0; io_wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      cfg_read(8'h30, d); chk("R12 enable after reset", d, 8'h00);
      cfg_read(8'h31, d); chk("R12 probe after reset", d, 8'h00);
      cfg_read(8'h60, d); chk("R12 base hi after reset", d, 8'h00);
      cfg_read(8'h61, d); chk("R12 base lo after reset", d, 8'h00);
      cfg_read(8'h70, d); chk("R12 level after reset", d, 8'h00);
      chk("R11 rdata idle", cfg_rdata, 8'h00);
      chk("R2 cs after reset", cs, 1'b0);
      chk("R9 irq after reset", irq_out, 16'h0);
   endtask

   task automatic t_register_masks();
      logic [7:0] d;
      cfg_write(8'h30, 8'hFF); cfg_read(8'h30, d); chk("R1 enable mask", d, 8'h01);
      cfg_write(8'h30, 8'hFE); cfg_read(8'h30, d); chk("R1 enable clear", d, 8'h00);
      cfg_write(8'h31, 8'hFF); cfg_read(8'h31, d); chk("R3 probe mask", d, 8'h03);
      cfg_write(8'h60, 8'hFF); cfg_read(8'h60, d); chk("R5 base hi mask", d, 8'h03);
      cfg_write(8'h61, 8'hFF); cfg_read(8'h61, d); chk("R6 base lo mask", d, 8'hF8);
      cfg_write(8'h70, 8'hFF); cfg_read(8'h70, d); chk("R8 level mask", d, 8'h0F);
      cfg_write(8'h71, 8'h00); cfg_read(8'h71, d); chk("R10 irq kind", d, 8'h03);
      cfg_write(8'h74, 8'hFF); cfg_read(8'h74, d); chk("R10 dma a", d, 8'h04);
      cfg_write(8'h75, 8'h00); cfg_read(8'h75, d); chk("R10 dma b", d, 8'h04);
      cfg_read(8'h40, d); chk("R11 unused index", d, 8'h00);
      cfg_read(8'h62, d); chk("R11 unused index 62", d, 8'h00);
      cfg_write(8'h31, 8'h00);
   endtask

   task automatic t_write_timing();
      @(negedge clk);
      cfg_idx = 8'h70; cfg_wdata = 8'h05; cfg_wr = 1'b1; cfg_rd = 1'b1;
      #1 chk("R12 old value before edge", cfg_rdata, 8'h0F);
      @(negedge clk);
      cfg_wr = 1'b0;
      #1 chk("R12 new value after edge", cfg_rdata, 8'h05);
      cfg_rd = 1'b0;
   endtask

   task automatic t_decode();
      cfg_write(8'h60, 8'h02);
      cfg_write(8'h61, 8'hF8);   // base 0x2F8
      cfg_write(8'h30, 8'h00);
      io_cycle(10'h2F8, 1'b1, 1'b0);
      chk("R2 no cs while off", cs, 1'b0);
      chk("R2 no drive while off", io_rdata_oe, 1'b0);
      io_idle();
      cfg_write(8'h30, 8'h01);
      io_cycle(10'h2FD, 1'b1, 1'b0);
      chk("R7 cs on read", cs, 1'b1);
      chk("R7 offset", reg_ofs, 3'd5);
      chk("R4 no probe drive when on", io_rdata_oe, 1'b0);
      io_cycle(10'h2F8, 1'b0, 1'b1);
      chk("R7 cs on write", cs, 1'b1);
      chk("R7 offset zero", reg_ofs, 3'd0);
      io_cycle(10'h300, 1'b1, 1'b0);
      chk("R7 no cs outside", cs, 1'b0);
      chk("R7 offset outside", reg_ofs, 3'd0);
      io_cycle(10'h0FF, 1'b0, 1'b1);
      chk("R7 no cs bit9 differs", cs, 1'b0);
      io_cycle(10'h2FF, 1'b0, 1'b0);
      chk("R7 no cs without strobe", cs, 1'b0);
      io_idle();
   endtask

   task automatic t_probe();
      cfg_write(8'h30, 8'h00);
      cfg_write(8'h31, 8'h03);
      io_cycle(10'h2FA, 1'b1, 1'b0);
      chk("R3 probe oe", io_rdata_oe, 1'b1);
      chk("R3 probe 55", io_rdata, 8'h55);
      chk("R2 no cs during probe", cs, 1'b0);
      io_idle();
      cfg_write(8'h31, 8'h02);
      io_cycle(10'h2FF, 1'b1, 1'b0);
      chk("R3 probe AA", io_rdata, 8'hAA);
      io_cycle(10'h2F0, 1'b1, 1'b0);
      chk("R3 probe outside", io_rdata_oe, 1'b0);
      chk("R3 probe outside data", io_rdata, 8'h00);
      io_cycle(10'h2F8, 1'b0, 1'b1);
      chk("R3 probe not on write", io_rdata_oe, 1'b0);
      io_idle();
      cfg_write(8'h31, 8'h01);
      io_cycle(10'h2F8, 1'b1, 1'b0);
      chk("R3 probe disarmed", io_rdata_oe, 1'b0);
      io_idle();
      cfg_write(8'h31, 8'h03);
      cfg_write(8'h30, 8'h01);
      io_cycle(10'h2F9, 1'b1, 1'b0);
      chk("R4 probe ignored when on", io_rdata_oe, 1'b0);
      chk("R4 data quiet when on", io_rdata, 8'h00);
      chk("R4 cs when on", cs, 1'b1);
      io_idle();
      cfg_write(8'h31, 8'h00);
   endtask

   task automatic t_irq();
      cfg_write(8'h30, 8'h01);
      cfg_write(8'h70, 8'h04);
      @(negedge clk); ctl_irq = 1'b1; #1;
      chk("R9 irq4 high", irq_out, 16'h0010);
      @(negedge clk); ctl_irq = 1'b0; #1;
      chk("R9 irq4 low", irq_out, 16'h0000);
      ctl_irq = 1'b1;
      cfg_write(8'h70, 8'h0C); #1;
      chk("R9 irq12", irq_out, 16'h1000);
      cfg_write(8'h70, 8'h02); #1;
      chk("R9 irq2", irq_out, 16'h0004);
      cfg_write(8'h70, 8'h08); #1;
      chk("R9 irq8 illegal", irq_out, 16'h0000);
      cfg_write(8'h70, 8'h00); #1;
      chk("R9 irq0 illegal", irq_out, 16'h0000);
      cfg_write(8'h70, 8'h0D); #1;
      chk("R9 irq13 illegal", irq_out, 16'h0000);
      cfg_write(8'h70, 8'h09); #1;
      chk("R9 irq9", irq_out, 16'h0200);
      cfg_write(8'h30, 8'h00); #1;
      chk("R9 irq off when disabled", irq_out, 16'h0000);
      ctl_irq = 1'b0;
   endtask

   task automatic t_reset_again();
      logic [7:0] d;
      cfg_write(8'h30, 8'h01);
      do_reset();
      cfg_read(8'h30, d); chk("R12 reset clears enable", d, 8'h00);
      cfg_read(8'h61, d); chk("R12 reset clears base", d, 8'h00);
      cfg_read(8'h70, d); chk("R12 reset clears level", d, 8'h00);
   endtask

   initial begin
      rst = 1'b1;
      cfg_idx = '0; cfg_wdata = '0; cfg_wr = 1'b0; cfg_rd = 1'b0;
      io_addr = '0; io_rd = 1'b0; io_wr = 1'b0; ctl_irq = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_register_masks();
      t_write_timing();
      t_decode();
      t_probe();
      t_irq();
      t_reset_again();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule